// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block derives the bit clock and the frame (left/right) clock of one audio serial port from the master clock, which is the block's `clk`: every `clk` cycle is one master clock period. Two 3-bit codes in a mode register set the number of master clocks per sample and the number of bit clocks per frame. Their quotient is the bit clock period in master clocks, and a quotient below 2 is rejected. When a combination is rejected, or when the port enable is low, both clocks hold their inactive level. Whenever generation starts again, or any configuration register is written, the clocks restart at the beginning of a frame.

Each data direction (output, input) selects its own role. In the master role a direction uses the generated clocks. In the slave role it uses the clocks arriving on the port pins. The pad drivers are enabled whenever at least one direction is master, and generation runs only in that case. A polarity register inverts the frame clock and the bit clock separately for the master role and for the slave role. A revision parameter sets whether the fastest ratio codes are accepted.

Top module: `aud_sclk_gen`

## Requirements
- R1: After reset both registers hold zero: both directions are slave, `pad_clk_oe` is 0, the pad clocks are 0 and the direction clocks follow the pins unchanged.
- R2: The mode register (cfg_addr 0) field at bits 14:12 sets master clocks per sample. Codes 0 to 3 give 512, 256, 128 and 64. The frame clock period equals that count in `clk` cycles.
- R3: The mode register field at bits 10:8 sets bit clocks per frame. Codes 0 to 4 give 32, 64, 128, 256 and 512. The bit clock period is the master-clock count divided by the bits-per-frame count, high for its second half.
- R4: Ratio code 4 (32 master clocks per sample) and frame code 7 (16 bit clocks per frame) are accepted only when REV is 2 or more. With REV 1 they are rejected and the clocks stay idle.
- R5: Frame codes 5 and 6, ratio codes 5 to 7, and any combination whose bit period would be below 2 master clocks hold both generated clocks at 0.
- R6: After a write to either register, or a rise of `port_en`, both generated clocks are 0. The bit clock first rises after half a bit period, and the frame clock stays 0 for the first half frame.
- R7: The frame clock changes level every half sample period, and it rises only on a cycle where the bit clock falls.
- R8: Mode bit 0 makes the output direction master, and mode bit 4 makes the input direction master. A master direction's clocks are the generated clocks, and a slave direction's clocks come from the pins. `pad_clk_oe` is 1 when either direction is master. With neither direction master, no clocks are generated.
- R9: Polarity register (cfg_addr 1) bit 12 inverts the master frame clock, bit 8 the master bit clock, bit 4 the slave frame clock and bit 0 the slave bit clock. The pad outputs carry the master polarity.
- R10: While `port_en` is 0 the generated clocks hold 0, so the pads show their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; one cycle per master clock period |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Enables clock generation for this port |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 selects the mode register, 1 the polarity register |
| cfg_wdata | input | CFG_W | Register write data |
| pin_bclk_i | input | 1 | Bit clock arriving from the port pin |
| pin_lrclk_i | input | 1 | Frame clock arriving from the port pin |
| pad_bclk_o | output | 1 | Generated bit clock toward the pin, master polarity applied |
| pad_lrclk_o | output | 1 | Generated frame clock toward the pin, master polarity applied |
| pad_clk_oe | output | 1 | Pad driver enable for both clocks |
| tx_bclk | output | 1 | Bit clock for the output direction |
| tx_lrclk | output | 1 | Frame clock for the output direction |
| rx_bclk | output | 1 | Bit clock for the input direction |
| rx_lrclk | output | 1 | Frame clock for the input direction |

## Verification
The bench targets the codes at the edges of the divide table: the shortest bit period of 2 master clocks, the out-of-sequence code 7, quotients that fall to 1, and the reserved codes. A wrong decode shows up as a clock at the wrong period, or as one that toggles when it should stay idle. It checks the phase of every restart from the write or enable cycle. A divider that does not clear would start mid-frame, with a frame clock that is high too early. The four polarity bits and the two role bits are set one at a time, so a swapped bit lands on the wrong pin. A second instance built with REV 1 must reject the codes that only the later revision accepts.

// File: rtl/aud_sclk_pkg.sv
// Shared field positions, register addresses and configuration types for
// the audio serial clock generator. Bit positions here are fixed by the
// register layout that software programs.
package aud_sclk_pkg;

    localparam int CODE_W       = 3;

    // register addresses
    localparam logic ADDR_MODE  = 1'b0;
    localparam logic ADDR_POL   = 1'b1;

    // mode register fields
    localparam int OUT_MS_BIT   = 0;
    localparam int IN_MS_BIT    = 4;
    localparam int BPF_LSB      = 8;
    localparam int RATIO_LSB    = 12;

    // polarity register fields
    localparam int INV_B_S_BIT  = 0;
    localparam int INV_LR_S_BIT = 4;
    localparam int INV_B_M_BIT  = 8;
    localparam int INV_LR_M_BIT = 12;

    typedef struct packed {
        logic [CODE_W-1:0] ratio_code;
        logic [CODE_W-1:0] bpf_code;
        logic              in_master;
        logic              out_master;
    } mode_cfg_t;

    typedef struct packed {
        logic inv_lr_m;
        logic inv_b_m;
        logic inv_lr_s;
        logic inv_b_s;
    } pol_cfg_t;

endpackage

// File: rtl/aud_sclk_regs.sv
// Configuration registers: the mode register (ratio codes, role bits) and
// the polarity register. Assumes single-cycle write strobes; the bits that
// carry no field are discarded.
module aud_sclk_regs
    import aud_sclk_pkg::*;
#(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output mode_cfg_t        mode_q,
    output pol_cfg_t         pol_q
);

    localparam logic [CFG_W-1:0] USED_MASK =
        (CFG_W'(7) << RATIO_LSB) | (CFG_W'(7) << BPF_LSB) |
        (CFG_W'(1) << IN_MS_BIT) | (CFG_W'(1) << OUT_MS_BIT) |
        (CFG_W'(1) << INV_LR_M_BIT) | (CFG_W'(1) << INV_B_M_BIT) |
        (CFG_W'(1) << INV_LR_S_BIT) | (CFG_W'(1) << INV_B_S_BIT);

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^(cfg_wdata & ~USED_MASK);

    // Mode register: captures ratio codes and direction roles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (cfg_wr && cfg_addr == ADDR_MODE) begin
            mode_q.ratio_code <= cfg_wdata[RATIO_LSB +: CODE_W];
            mode_q.bpf_code   <= cfg_wdata[BPF_LSB +: CODE_W];
            mode_q.in_master  <= cfg_wdata[IN_MS_BIT];
            mode_q.out_master <= cfg_wdata[OUT_MS_BIT];
        end
    end

    // Polarity register: one invert bit per clock and role.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= '0;
        end else if (cfg_wr && cfg_addr == ADDR_POL) begin
            pol_q.inv_lr_m <= cfg_wdata[INV_LR_M_BIT];
            pol_q.inv_b_m  <= cfg_wdata[INV_B_M_BIT];
            pol_q.inv_lr_s <= cfg_wdata[INV_LR_S_BIT];
            pol_q.inv_b_s  <= cfg_wdata[INV_B_S_BIT];
        end
    end

endmodule

// File: rtl/aud_sclk_decode.sv
// Ratio decoder: turns the two 3-bit codes into log2 of master clocks per
// sample and log2 of the bit clock period, and flags invalid settings.
// Assumes every ratio is a power of two, so the quotient is a difference
// of logarithms.
module aud_sclk_decode
    import aud_sclk_pkg::*;
#(
    parameter int REV           = 2,
    parameter int RATIO_LOG_TOP = 9,
    parameter int BPF_LOG_BASE  = 5,
    parameter int LOG_W         = 4
) (
    input  logic [CODE_W-1:0] ratio_code,
    input  logic [CODE_W-1:0] bpf_code,
    output logic [LOG_W-1:0]  ratio_log,
    output logic [LOG_W-1:0]  div_log,
    output logic              cfg_ok
);

    localparam bit LATE_REV = (REV >= 2);

    logic [LOG_W-1:0] r_log;
    logic [LOG_W-1:0] b_log;
    logic             r_ok;
    logic             b_ok;

    // Master clocks per sample: codes 0..4 halve from the top ratio.
    always_comb begin
        r_log = '0;
        r_ok  = 1'b0;
        if (ratio_code <= CODE_W'(4)) begin
            r_log = LOG_W'(RATIO_LOG_TOP) - LOG_W'(ratio_code);
            r_ok  = (ratio_code != CODE_W'(4)) || LATE_REV;
        end
    end

    // Bit clocks per frame: codes 0..4 double from the base, code 7 halves it.
    always_comb begin
        b_log = '0;
        b_ok  = 1'b0;
        if (bpf_code <= CODE_W'(4)) begin
            b_log = LOG_W'(BPF_LOG_BASE) + LOG_W'(bpf_code);
            b_ok  = 1'b1;
        end else if (bpf_code == CODE_W'(7)) begin
            b_log = LOG_W'(BPF_LOG_BASE - 1);
            b_ok  = LATE_REV;
        end
    end

    // Bit period must be at least two master clocks.
    always_comb begin
        cfg_ok    = r_ok && b_ok && (r_log > b_log);
        ratio_log = r_log;
        div_log   = cfg_ok ? (r_log - b_log) : '0;
    end

endmodule

// File: rtl/aud_sclk_divider.sv
// Frame counter: counts master clocks within one sample period and derives
// the bit clock and the frame clock from its bits. Assumes power-of-two
// ratios; clears to the frame start whenever idle or restarted.
module aud_sclk_divider #(
    parameter int CNT_W = 9,
    parameter int LOG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [LOG_W-1:0] ratio_log,
    input  logic [LOG_W-1:0] div_log,
    output logic             gen_bclk,
    output logic             gen_lrclk
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   wrap_mask;
    logic [CNT_W-1:0] bclk_sh;
    logic [CNT_W-1:0] lr_sh;
    logic [LOG_W-1:0] bclk_sel;
    logic [LOG_W-1:0] lr_sel;

    // Mask that wraps the counter at the sample length.
    always_comb begin
        wrap_mask = ((CNT_W+1)'(1) << ratio_log) - (CNT_W+1)'(1);
    end

    // Sample-period counter, held at the frame start while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= (cnt_q + CNT_W'(1)) & wrap_mask[CNT_W-1:0];
        end
    end

    // Clock bits: top bit of the bit period and of the sample period.
    always_comb begin
        bclk_sel  = div_log - LOG_W'(1);
        lr_sel    = ratio_log - LOG_W'(1);
        bclk_sh   = cnt_q >> bclk_sel;
        lr_sh     = cnt_q >> lr_sel;
        gen_bclk  = run & bclk_sh[0];
        gen_lrclk = run & lr_sh[0];
    end

endmodule

// File: rtl/aud_sclk_route.sv
// Role router: for each data direction picks the generated clocks (master)
// or the pin clocks (slave) and applies the polarity bits of that role.
module aud_sclk_route
    import aud_sclk_pkg::*;
#(
    parameter int N_DIR = 2
) (
    input  logic [N_DIR-1:0] dir_master,
    input  logic             gen_bclk,
    input  logic             gen_lrclk,
    input  logic             pin_bclk,
    input  logic             pin_lrclk,
    input  pol_cfg_t         pol,
    output logic [N_DIR-1:0] dir_bclk,
    output logic [N_DIR-1:0] dir_lrclk
);

    logic m_bclk;
    logic m_lrclk;
    logic s_bclk;
    logic s_lrclk;

    // Clocks with role polarity applied.
    always_comb begin
        m_bclk  = gen_bclk  ^ pol.inv_b_m;
        m_lrclk = gen_lrclk ^ pol.inv_lr_m;
        s_bclk  = pin_bclk  ^ pol.inv_b_s;
        s_lrclk = pin_lrclk ^ pol.inv_lr_s;
    end

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        // Per-direction role select.
        always_comb begin
            dir_bclk[d]  = dir_master[d] ? m_bclk  : s_bclk;
            dir_lrclk[d] = dir_master[d] ? m_lrclk : s_lrclk;
        end
    end

endmodule

// File: rtl/aud_sclk_gen.sv
// Audio serial clock generator for one port. The clk input is the master
// clock. Generation runs while the port is enabled, the codes are valid and
// at least one direction is master; any register write restarts the frame.
module aud_sclk_gen
    import aud_sclk_pkg::*;
#(
    parameter int REV           = 2,
    parameter int CFG_W         = 16,
    parameter int RATIO_LOG_TOP = 9,
    parameter int BPF_LOG_BASE  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic             cfg_wr,
    input  logic             cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             pin_bclk_i,
    input  logic             pin_lrclk_i,
    output logic             pad_bclk_o,
    output logic             pad_lrclk_o,
    output logic             pad_clk_oe,
    output logic             tx_bclk,
    output logic             tx_lrclk,
    output logic             rx_bclk,
    output logic             rx_lrclk
);

    localparam int LOG_W = $clog2(RATIO_LOG_TOP + 1);
    localparam int CNT_W = RATIO_LOG_TOP;
    localparam int N_DIR = 2;

    mode_cfg_t        mode_q;
    pol_cfg_t         pol_q;
    logic [LOG_W-1:0] ratio_log;
    logic [LOG_W-1:0] div_log;
    logic             cfg_ok;
    logic             gen_run;
    logic             gen_bclk;
    logic             gen_lrclk;
    logic [N_DIR-1:0] dir_master;
    logic [N_DIR-1:0] dir_bclk;
    logic [N_DIR-1:0] dir_lrclk;

    aud_sclk_regs #(.CFG_W(CFG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .mode_q    (mode_q),
        .pol_q     (pol_q)
    );

    aud_sclk_decode #(
        .REV           (REV),
        .RATIO_LOG_TOP (RATIO_LOG_TOP),
        .BPF_LOG_BASE  (BPF_LOG_BASE),
        .LOG_W         (LOG_W)
    ) u_decode (
        .ratio_code (mode_q.ratio_code),
        .bpf_code   (mode_q.bpf_code),
        .ratio_log  (ratio_log),
        .div_log    (div_log),
        .cfg_ok     (cfg_ok)
    );

    // Roles per direction: index 0 output, index 1 input; run condition.
    always_comb begin
        dir_master = {mode_q.in_master, mode_q.out_master};
        pad_clk_oe = |dir_master;
        gen_run    = port_en & cfg_ok & pad_clk_oe;
    end

    aud_sclk_divider #(.CNT_W(CNT_W), .LOG_W(LOG_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (gen_run),
        .restart   (cfg_wr),
        .ratio_log (ratio_log),
        .div_log   (div_log),
        .gen_bclk  (gen_bclk),
        .gen_lrclk (gen_lrclk)
    );

    aud_sclk_route #(.N_DIR(N_DIR)) u_route (
        .dir_master (dir_master),
        .gen_bclk   (gen_bclk),
        .gen_lrclk  (gen_lrclk),
        .pin_bclk   (pin_bclk_i),
        .pin_lrclk  (pin_lrclk_i),
        .pol        (pol_q),
        .dir_bclk   (dir_bclk),
        .dir_lrclk  (dir_lrclk)
    );

    // Pad drive carries the master polarity; direction clocks from router.
    always_comb begin
        pad_bclk_o  = gen_bclk  ^ pol_q.inv_b_m;
        pad_lrclk_o = gen_lrclk ^ pol_q.inv_lr_m;
        tx_bclk     = dir_bclk[0];
        tx_lrclk    = dir_lrclk[0];
        rx_bclk     = dir_bclk[1];
        rx_lrclk    = dir_lrclk[1];
    end

endmodule

// File: rtl/aud_sclk_gen_chk.sv
// Property checker for the clock generator, bound to every instance.
module aud_sclk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic port_en,
    input logic pad_clk_oe,
    input logic cfg_ok,
    input logic gen_run,
    input logic gen_bclk,
    input logic gen_lrclk
);

    // Generation starts at a frame boundary with both clocks low.
    assert_restart_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_run) |-> (!gen_bclk && !gen_lrclk));

    // The frame clock rises only together with a bit clock fall.
    assert_frame_on_bit_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_lrclk) |-> $fell(gen_bclk));

    // Rejected codes keep the divider quiet.
    assert_invalid_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |-> (!gen_bclk && !gen_lrclk));

    // No master direction means no generated clocks.
    assert_no_master_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_clk_oe |-> (!gen_bclk && !gen_lrclk));

    // A disabled port generates nothing.
    assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> (!gen_bclk && !gen_lrclk));

endmodule

bind aud_sclk_gen aud_sclk_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_en    (port_en),
    .pad_clk_oe (pad_clk_oe),
    .cfg_ok     (cfg_ok),
    .gen_run    (gen_run),
    .gen_bclk   (gen_bclk),
    .gen_lrclk  (gen_lrclk)
);

// File: tb/aud_sclk_gen_bench.sv
`timescale 1ns/1ps
module aud_sclk_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        pin_bclk_i = 1'b0;
    logic        pin_lrclk_i = 1'b0;

    logic pad_bclk_o, pad_lrclk_o, pad_clk_oe;
    logic tx_bclk, tx_lrclk, rx_bclk, rx_lrclk;
    logic r1_pad_bclk, r1_pad_lrclk, r1_oe;
    logic r1_tx_b, r1_tx_l, r1_rx_b, r1_rx_l;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;

    aud_sclk_gen u_aud_sclk_gen (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pin_bclk_i(pin_bclk_i), .pin_lrclk_i(pin_lrclk_i),
        .pad_bclk_o(pad_bclk_o), .pad_lrclk_o(pad_lrclk_o), .pad_clk_oe(pad_clk_oe),
        .tx_bclk(tx_bclk), .tx_lrclk(tx_lrclk), .rx_bclk(rx_bclk), .rx_lrclk(rx_lrclk)
    );

    aud_sclk_gen #(.REV(1)) u_aud_sclk_gen_rev1 (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pin_bclk_i(pin_bclk_i), .pin_lrclk_i(pin_lrclk_i),
        .pad_bclk_o(r1_pad_bclk), .pad_lrclk_o(r1_pad_lrclk), .pad_clk_oe(r1_oe),
        .tx_bclk(r1_tx_b), .tx_lrclk(r1_tx_l), .rx_bclk(r1_rx_b), .rx_lrclk(r1_rx_l)
    );

    // Vector: {ratio code, frame code, master clocks per sample (0 = idle), bit period}
    localparam int NV = 12;
    localparam logic [25:0] VT [NV] = '{
        {3'd0, 3'd0, 10'd512, 10'd16},
        {3'd1, 3'd1, 10'd256, 10'd4},
        {3'd2, 3'd0, 10'd128, 10'd4},
        {3'd3, 3'd0, 10'd64,  10'd2},
        {3'd4, 3'd7, 10'd32,  10'd2},
        {3'd0, 3'd4, 10'd0,   10'd0},
        {3'd5, 3'd0, 10'd0,   10'd0},
        {3'd0, 3'd6, 10'd0,   10'd0},
        {3'd0, 3'd7, 10'd512, 10'd32},
        {3'd3, 3'd1, 10'd0,   10'd0},
        {3'd0, 3'd3, 10'd512, 10'd2},
        {3'd2, 3'd2, 10'd0,   10'd0}
    };

    function automatic logic [15:0] mode_word(int r, int b, bit in_m, bit out_m);
        return {1'b0, 3'(r), 1'b0, 3'(b), 3'b000, in_m, 3'b000, out_m};
    endfunction

    task automatic check1(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Write a register; returns at the negedge right after the write edge.
    task automatic wr(input logic addr, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = addr; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Compare one clock pair against the expected waveform from frame start.
    // sel 0: pads of main instance, 1: input direction, 2: pads of REV 1 instance.
    task automatic run_check(input int sel, input int m, input int p,
                             input int cycles, input string tag);
        int  bad = 0;
        logic ab = 1'b0, al = 1'b0, eb = 1'b0, el = 1'b0;
        for (int k = 0; k < cycles; k++) begin
            logic ob, ol, xb, xl;
            case (sel)
                0: begin ob = pad_bclk_o;  ol = pad_lrclk_o;  end
                1: begin ob = rx_bclk;     ol = rx_lrclk;     end
                default: begin ob = r1_pad_bclk; ol = r1_pad_lrclk; end
            endcase
            xb = (m != 0) && ((k % p) >= p / 2);
            xl = (m != 0) && ((k % m) >= m / 2);
            if ((ob !== xb || ol !== xl) && bad == 0) begin
                ab = ob; al = ol; eb = xb; el = xl;
            end
            if (ob !== xb || ol !== xl) bad++;
            @(negedge clk);
        end
        n_checks++;
        if (bad != 0) begin
            n_fails++;
            $display("FAIL %s: actual bclk/lrclk %b/%b expected %b/%b (%0d bad cycles)",
                     tag, ab, al, eb, el, bad);
        end
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        pin_bclk_i = 1'b1; pin_lrclk_i = 1'b0;
        #1;
        check1("R1 oe", pad_clk_oe, 1'b0);
        check1("R1 pad bclk", pad_bclk_o, 1'b0);
        check1("R1 pad lrclk", pad_lrclk_o, 1'b0);
        check1("R1 tx bclk follows pin", tx_bclk, 1'b1);
        check1("R1 rx lrclk follows pin", rx_lrclk, 1'b0);
        pin_bclk_i = 1'b0;

        // Table walk: R2 R3 R4 R5 R6 R7, output direction master
        port_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            int r = int'(VT[i][25:23]);
            int b = int'(VT[i][22:20]);
            int m = int'(VT[i][19:10]);
            int p = int'(VT[i][9:0]);
            string tag;
            if (m == 0) tag = $sformatf("R5 vec %0d", i);
            else if (r == 4 || b == 7) tag = $sformatf("R4 vec %0d", i);
            else tag = $sformatf("R2 R3 R6 R7 vec %0d", i);
            wr(1'b0, mode_word(r, b, 1'b0, 1'b1));
            run_check(0, m, p, (m != 0) ? 2 * m : 64, tag);
        end

        // R4: REV 1 instance rejects the late-revision codes
        wr(1'b0, mode_word(4, 7, 1'b0, 1'b1));
        run_check(2, 0, 0, 64, "R4 rev1 ratio code 4");
        wr(1'b0, mode_word(0, 7, 1'b0, 1'b1));
        run_check(2, 0, 0, 64, "R4 rev1 frame code 7");
        wr(1'b0, mode_word(3, 0, 1'b0, 1'b1));
        run_check(2, 64, 2, 128, "R4 rev1 accepts code 3");

        // R10: disable mid-run, then restart phase-aligned (R6)
        wr(1'b0, mode_word(2, 0, 1'b0, 1'b1));
        repeat (37) @(negedge clk);
        port_en = 1'b0;
        run_check(0, 0, 0, 40, "R10 disabled idle");
        port_en = 1'b1;
        run_check(0, 128, 4, 256, "R10 R6 re-enable phase");

        // R8: input direction master only
        wr(1'b0, mode_word(3, 0, 1'b1, 1'b0));
        pin_bclk_i = 1'b1; pin_lrclk_i = 1'b0;
        #1;
        check1("R8 oe with input master", pad_clk_oe, 1'b1);
        check1("R8 tx bclk from pin", tx_bclk, 1'b1);
        check1("R8 tx lrclk from pin", tx_lrclk, 1'b0);
        @(negedge clk);
        wr(1'b0, mode_word(3, 0, 1'b1, 1'b0));
        run_check(1, 64, 2, 128, "R8 rx uses generated clocks");

        // R8: output master only, input slave follows pins
        wr(1'b0, mode_word(3, 0, 1'b0, 1'b1));
        pin_bclk_i = 1'b0; pin_lrclk_i = 1'b1;
        #1;
        check1("R8 rx bclk from pin", rx_bclk, 1'b0);
        check1("R8 rx lrclk from pin", rx_lrclk, 1'b1);
        pin_lrclk_i = 1'b0;

        // R8: no master, no clocks
        wr(1'b0, mode_word(3, 0, 1'b0, 1'b0));
        #1;
        check1("R8 oe with no master", pad_clk_oe, 1'b0);
        @(negedge clk);
        run_check(0, 0, 0, 32, "R8 no master idle");

        // R9: each polarity bit alone, generation idle, input direction slave
        wr(1'b0, mode_word(3, 0, 1'b0, 1'b1));
        port_en = 1'b0;
        pin_bclk_i = 1'b0; pin_lrclk_i = 1'b0;
        wr(1'b1, 16'h1000);
        #1;
        check1("R9 bit12 pad lrclk", pad_lrclk_o, 1'b1);
        check1("R9 bit12 pad bclk", pad_bclk_o, 1'b0);
        check1("R9 bit12 tx lrclk", tx_lrclk, 1'b1);
        wr(1'b1, 16'h0100);
        #1;
        check1("R9 bit8 pad bclk", pad_bclk_o, 1'b1);
        check1("R9 bit8 pad lrclk", pad_lrclk_o, 1'b0);
        wr(1'b1, 16'h0010);
        #1;
        check1("R9 bit4 rx lrclk", rx_lrclk, 1'b1);
        check1("R9 bit4 rx bclk", rx_bclk, 1'b0);
        check1("R9 bit4 pad lrclk", pad_lrclk_o, 1'b0);
        wr(1'b1, 16'h0001);
        #1;
        check1("R9 bit0 rx bclk", rx_bclk, 1'b1);
        check1("R9 bit0 rx lrclk", rx_lrclk, 1'b0);

        // R9: polarity write leaves the mode register intact
        wr(1'b1, 16'h0000);
        port_en = 1'b1;
        run_check(0, 64, 2, 128, "R9 mode kept after polarity write");

        finish_run();
    end

endmodule